// File: doc/BRIEF.md
# Queued-Transmit SPI Master

This block is a byte-wide SPI master with a two-stage transmit path (a holding buffer in front of the shift register) and a single receive data register. A CPU talks to it through three strobes: a data write, a data read, and a status read. The three status flags are always visible as outputs. A byte written while another is shifting waits in the holding buffer. That byte enters the shift register on the same system clock edge that ends the current byte, so a stream of writes produces an unbroken serial clock.

The serial clock idles low. Each bit is driven onto MOSI at the rising (leading) edge and MISO is sampled at the falling (trailing) edge. Each half period of the serial clock lasts `SCK_HALF` system clocks, so the divider is `2*SCK_HALF`, which is at least 2. Bytes go out most-significant bit first. The byte shifted in from MISO lands in the receive register. A receive-full flag raised there is cleared only by a status read followed by a data read. A byte that arrives while the flag is still up overwrites the register and sets a sticky overrun flag.

Top module: `spi_queued_master`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0, overrun is 0, and sck and mosi are 0.
- R2: A wr_en pulse while tx_empty is 1 stores wr_data in the holding buffer and drops tx_empty one clock later. A wr_en pulse while tx_empty is 0 is ignored, and that byte is never sent.
- R3: When the shifter is idle and the buffer holds a byte, the byte enters the shifter on the next clock and tx_empty returns to 1. When a byte finishes with another queued, tx_empty returns to 1 on the clock that ends the byte.
- R4: sck idles low and each half period is SCK_HALF clocks. mosi changes only with a rising sck. miso is sampled at a falling sck. Each byte is 8 bits, most-significant bit first.
- R5: A queued byte follows the current one with no gap: the rising sck edges across a byte boundary are 2*SCK_HALF clocks apart, like those inside a byte.
- R6: On the clock of the 8th falling sck edge, the received byte appears on rd_data and rx_full is set.
- R7: rx_full clears only after a stat_rd pulse seen while rx_full is 1, followed later by a data_rd pulse. A data_rd pulse with no such earlier status read leaves rx_full at 1.
- R8: A byte that completes while rx_full is 1 replaces rd_data and sets overrun. overrun stays set until the same status-then-data read sequence, which clears it together with rx_full.
- R9: With nothing in the shifter or buffer, sck stays low and no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Byte to transmit |
| stat_rd | input | 1 | Status read strobe (arms the flag clear) |
| data_rd | input | 1 | Data read strobe (completes the flag clear) |
| miso | input | 1 | Serial data from the slave |
| rd_data | output | 8 | Receive data register |
| tx_empty | output | 1 | Holding buffer can accept a byte |
| rx_full | output | 1 | Unread received byte present |
| overrun | output | 1 | A received byte was overwritten (sticky) |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |

## Verification
A single isolated byte shows the path from load to shift and checks bit order against fixed, asymmetric patterns on both serial lines. A directed pair of queued bytes is sent with a third write pushed while the buffer is full. This separates a correct queue from one that overwrites or drops, and it also triggers an overrun with the data it must leave behind. A long stream of bytes from a fixed-seed $urandom source keeps the buffer permanently refilled. It exposes any idle gap between bytes and any mismatch between the bytes the slave model sees and the bytes the CPU reads back. Separate reads, a data read without the status read and then the full sequence, tell apart the correct clearing rule from one that clears on any read.

// File: rtl/spi_queued_master.sv
module spi_queued_master #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       stat_rd,
  input  logic       data_rd,
  input  logic       miso,
  output logic [7:0] rd_data,
  output logic       tx_empty,
  output logic       rx_full,
  output logic       overrun,
  output logic       sck,
  output logic       mosi
);

  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic [7:0]    hold_q;
  logic          hold_full;
  logic [7:0]    shreg;
  logic          busy;
  logic          sck_q;
  logic          mosi_q;
  logic [2:0]    bit_cnt;
  logic [CW-1:0] div_cnt;
  logic [7:0]    rx_q;
  logic          rxf_q;
  logic          ovr_q;
  logic          armed;

  logic       tick, rise, fall, last, start, load, rd_clear;
  logic [7:0] shifted;

  assign tick     = busy && (div_cnt == CW'(SCK_HALF - 1));
  assign rise     = tick && !sck_q;
  assign fall     = tick && sck_q;
  assign last     = fall && (bit_cnt == 3'd7);
  assign start    = !busy && hold_full;
  assign load     = start || (last && hold_full);
  assign shifted  = {shreg[6:0], miso};
  assign rd_clear = data_rd && armed;

  assign rd_data  = rx_q;
  assign tx_empty = !hold_full;
  assign rx_full  = rxf_q;
  assign overrun  = ovr_q;
  assign sck      = sck_q;
  assign mosi     = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
      bit_cnt <= 3'd0;
      shreg   <= 8'h00;
      busy    <= 1'b0;
    end else begin
      if (!busy || tick) div_cnt <= '0;
      else               div_cnt <= div_cnt + 1'b1;
      if (tick) sck_q <= !sck_q;
      if (rise) mosi_q <= shreg[7];
      if (fall) begin
        bit_cnt <= bit_cnt + 3'd1;
        shreg   <= shifted;
      end
      if (load) shreg <= hold_q;
      if (start)                      busy <= 1'b1;
      else if (last && !hold_full)    busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 8'h00;
      hold_full <= 1'b0;
    end else if (load) begin
      hold_full <= 1'b0;
    end else if (wr_en && !hold_full) begin
      hold_q    <= wr_data;
      hold_full <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= 8'h00;
      rxf_q <= 1'b0;
      ovr_q <= 1'b0;
      armed <= 1'b0;
    end else if (last) begin
      rx_q  <= shifted;
      rxf_q <= 1'b1;
      ovr_q <= (ovr_q && !rd_clear) || (rxf_q && !rd_clear);
      armed <= 1'b0;
    end else if (rd_clear) begin
      rxf_q <= 1'b0;
      ovr_q <= 1'b0;
      armed <= 1'b0;
    end else if (stat_rd && rxf_q) begin
      armed <= 1'b1;
    end
  end

endmodule

module spi_queued_master_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic data_rd,
  input logic tx_empty,
  input logic rx_full,
  input logic overrun,
  input logic sck,
  input logic mosi,
  input logic busy
);

  AST_MOSI_STILL_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> $stable(mosi)); // R4

  AST_WRITE_FILLS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_empty) |=> !tx_empty); // R2

  AST_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> busy); // R3

  AST_RXFULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !data_rd) |=> rx_full); // R7

  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_full)); // R8

  AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck); // R9

endmodule

bind spi_queued_master spi_queued_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .data_rd(data_rd),
  .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun),
  .sck(sck), .mosi(mosi), .busy(busy)
);

// File: tb/test_spi_queued_master.sv
module test_spi_queued_master;
  localparam int HALF = 2;
  localparam int NRAND = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, stat_rd = 1'b0, data_rd = 1'b0, miso = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic tx_empty, rx_full, overrun, sck, mosi;

  spi_queued_master #(.SCK_HALF(HALF)) i_spi_queued_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stat_rd(stat_rd), .data_rd(data_rd), .miso(miso), .rd_data(rd_data),
    .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun),
    .sck(sck), .mosi(mosi));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic [7:0] miso_b [64];
  logic [7:0] tx_b   [64];
  logic [7:0] seen   [64];
  int rise_t [128];
  int n_rise = 0, s_mbit = 0, s_tidx = 0, s_rbit = 0, s_ridx = 0;
  logic [7:0] got = 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge sck) begin
    if (n_rise < 128) rise_t[n_rise] = cyc;
    n_rise = n_rise + 1;
    miso = miso_b[s_tidx % 64][7 - s_mbit];
    s_mbit = s_mbit + 1;
    if (s_mbit == 8) begin s_mbit = 0; s_tidx = s_tidx + 1; end
  end

  always @(negedge sck) begin
    got = {got[6:0], mosi};
    s_rbit = s_rbit + 1;
    if (s_rbit == 8) begin
      s_rbit = 0;
      seen[s_ridx % 64] = got;
      s_ridx = s_ridx + 1;
    end
  end

  function automatic bit same8(input logic [7:0] a, input logic [7:0] b);
    return a === b;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    wr_data = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic get(output logic [7:0] v);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0; data_rd = 1'b1; v = rd_data;
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    int gap_bad;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 64; k++) begin
      miso_b[k] = 8'($urandom);
      tx_b[k]   = 8'($urandom);
    end
    tx_b[0] = 8'hA5; miso_b[0] = 8'h3C;
    tx_b[1] = 8'h81; miso_b[1] = 8'hC6;
    tx_b[2] = 8'h7E; miso_b[2] = 8'h19;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_empty", int'(tx_empty), 1);
    chk("R1 rx_full", int'(rx_full), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 sck", int'(sck), 0);
    chk("R1 mosi", int'(mosi), 0);

    repeat (20) @(negedge clk);
    chk("R9 no clock while empty", n_rise, 0);

    put(tx_b[0]);
    chk("R2 write drops tx_empty", int'(tx_empty), 0);
    @(negedge clk);
    chk("R3 idle load raises tx_empty", int'(tx_empty), 1);
    while (!rx_full) @(negedge clk);
    chk("R4 byte0 on mosi msb first", int'(seen[0]), int'(tx_b[0]));
    chk("R6 byte0 received", int'(rd_data), int'(miso_b[0]));
    chk("R4 half period", rise_t[1] - rise_t[0], 2 * HALF);

    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    @(negedge clk);
    chk("R7 data read alone keeps rx_full", int'(rx_full), 1);
    get(v);
    chk("R7 status then data clears", int'(rx_full), 0);

    put(tx_b[1]);
    @(negedge clk);
    put(tx_b[2]);
    chk("R2 queued write drops tx_empty", int'(tx_empty), 0);
    put(8'hFF);
    chk("R2 write while full keeps tx_empty low", int'(tx_empty), 0);
    while (!rx_full) @(negedge clk);
    chk("R3 boundary load raises tx_empty", int'(tx_empty), 1);
    while (!overrun) @(negedge clk);
    chk("R8 overwrite data", int'(rd_data), int'(miso_b[2]));
    chk("R8 rx_full kept", int'(rx_full), 1);
    chk("R5 gapless boundary", rise_t[16] - rise_t[15], 2 * HALF);
    chk("R2 queued byte kept", int'(seen[2]), int'(tx_b[2]));
    chk("R4 byte1 order", int'(seen[1]), int'(tx_b[1]));
    repeat (60) @(negedge clk);
    chk("R2 ignored byte never sent", s_ridx, 3);
    chk("R9 clock stays low after stream", int'(sck), 0);
    chk("R8 overrun sticky", int'(overrun), 1);
    get(v);
    chk("R8 overrun cleared", int'(overrun), 0);
    chk("R8 rx_full cleared", int'(rx_full), 0);

    for (int i = 3; i < 3 + NRAND; i++) begin
      while (!tx_empty) @(negedge clk);
      put(tx_b[i]);
      if (rx_full) begin
        get(v);
        chk("R6 stream rx data", int'(v), int'(miso_b[s_ridx - 1]));
      end
    end
    while (s_ridx < 3 + NRAND || rx_full) begin
      if (rx_full) begin
        get(v);
        chk("R6 drain rx data", int'(v), int'(miso_b[s_ridx - 1]));
      end else @(negedge clk);
    end
    chk("R8 no overrun when read in time", int'(overrun), 0);
    for (int i = 3; i < 3 + NRAND; i++)
      if (!same8(seen[i], tx_b[i])) chk("R4 stream mosi byte", int'(seen[i]), int'(tx_b[i]));
    n_chk++;
    gap_bad = 0;
    for (int j = 25; j < 24 + 8 * NRAND && j < 128; j++)
      if (rise_t[j] - rise_t[j-1] != 2 * HALF) gap_bad++;
    chk("R5 stream gapless", gap_bad, 0);
    summary();
  end
endmodule